// File: doc/BRIEF.md
# Image Sensor Register Table Initializer

This block brings an image sensor out of power-up by programming its configuration registers over a two-wire serial control bus. When a start request arrives, it first issues a soft reset to the sensor and then waits a long settling time. Next it walks a constant table of register address and value pairs held inside the block. Each pair is sent as its own write transaction, with a short fixed gap after every transaction. Once the table is exhausted, one closing write keeps the pixel clock quiet during horizontal blanking. A one-cycle done pulse then signals that the sensor is configured.

The bus engine is built in. It drives both lines open-drain: a high output pulls the line low, and the line is released otherwise. It reads the data line back to check acknowledges. If an acknowledge is missing on any byte, the block closes the bus with a STOP, raises its error output and does nothing more until the next start request. The bit rate and both delays are parameters, each expressed as a number of system clock cycles.

Top module: `cam_reg_init`

## Requirements
- R1: A start request in idle or error state begins a run. The first transaction writes value 0x80 to register 0x12 and is sent as the three bytes 0x42, 0x12, 0x80 between a START and a STOP.
- R2: SDA changes only while SCL is low, except for START (SDA falls while SCL is high) and STOP (SDA rises while SCL is high). Bytes are sent most significant bit first. Both lines are released whenever no transaction is in progress, including after reset.
- R3: Between the STOP of the reset write and the next START there are at least RST_WAIT_CYC and at most RST_WAIT_CYC+4*QDIV+4 clock cycles.
- R4: The table entries, written as (register, value) in this order, are (0x3A,0x04), (0x0C,0x04), (0xFF,0x00), (0x40,0xC0), (0x55,0xFF), (0x11,0x0C), followed by the end entry (0xFF,0xFF). Each non-end entry is written in table order as 0x42, register, value.
- R5: Only an entry whose register and value are both 0xFF ends the table, and that entry is never sent. An entry with only one byte equal to 0xFF is sent like any other.
- R6: After every table write, at least GAP_CYC and at most GAP_CYC+4*QDIV+4 cycles pass between its STOP and the next START.
- R7: After the last table entry, the block writes value 0x20 to register 0x15 as its final transaction. A full run therefore has exactly 8 transactions.
- R8: done is high for exactly one cycle, within 2*QDIV+4 cycles after the STOP of the final write. It is low after reset and is never high while err is high.
- R9: A missing acknowledge (SDA high at the acknowledge bit) after any of the three bytes ends that transaction with a STOP. err then goes high and stays high, no further transaction starts, and done does not pulse. A new start request clears err and restarts the whole run.
- R10: A start request while a run is in progress has no effect on the transaction sequence or on the single done pulse.
- R11: Successive SCL rising edges within a transaction are exactly 4*QDIV system clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to run the full initialization sequence |
| sda_in | input | 1 | Level of the shared data line, read back for acknowledges |
| done | output | 1 | One-cycle pulse when the final write has completed |
| err | output | 1 | High after a missing acknowledge, until the next start |
| scl_lo | output | 1 | When high, pulls the clock line low; when low, releases it |
| sda_lo | output | 1 | When high, pulls the data line low; when low, releases it |

## Verification
A bus-level sensor model decodes START, STOP and bytes from the line levels and acknowledges each byte. A clean full run compares every byte of every transaction against the table. That run shows whether the reset write, the table order, the one-byte-0xFF entries, the end marker and the closing write are each handled correctly. It also measures the stop-to-start spacings, so a swapped or shortened reset wait or gap shows up. Missing acknowledges are injected on the first byte of the first transaction, the register byte of a middle one and the data byte of the last one. These runs show that each acknowledge slot is checked and that the error path halts the bus. A further run repeats start requests during both transfer and wait phases, and a run after an error shows that a restart clears the error.

// File: rtl/cam_reg_init.sv
module cam_reg_init #(
  parameter int QDIV         = 312,
  parameter int GAP_CYC      = 125000,
  parameter int RST_WAIT_CYC = 12500000,
  parameter logic [7:0] DEV_ADDR = 8'h42
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sda_in,
  output logic done,
  output logic err,
  output logic scl_lo,
  output logic sda_lo
);

  localparam int QW   = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam int WMAX = (RST_WAIT_CYC > GAP_CYC) ? RST_WAIT_CYC : GAP_CYC;
  localparam int WW   = $clog2(WMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_WAIT, S_FAIL} seq_t;
  typedef enum logic [1:0] {P_RST, P_TBL, P_TAIL} part_t;
  typedef enum logic [1:0] {T_START, T_BITS, T_STOP} tx_t;

  seq_t  state;
  part_t part;
  tx_t   tx;
  logic [2:0]    idx;
  logic [QW-1:0] tick;
  logic [1:0]    qtr;
  logic [1:0]    byte_k;
  logic [3:0]    bit_i;
  logic          nack;
  logic [WW-1:0] wcnt;
  logic          sda_m, sda_s;
  logic [15:0]   cur_pair;
  logic [7:0]    cur_byte;
  logic          tx_bit, scl_c, sda_c, qstep, is_end;

  function automatic logic [15:0] tbl_entry(input logic [2:0] i);
    case (i)
      3'd0:    return {8'h3A, 8'h04};
      3'd1:    return {8'h0C, 8'h04};
      3'd2:    return {8'hFF, 8'h00};
      3'd3:    return {8'h40, 8'hC0};
      3'd4:    return {8'h55, 8'hFF};
      3'd5:    return {8'h11, 8'h0C};
      default: return 16'hFFFF;
    endcase
  endfunction

  assign qstep  = (tick == QW'(QDIV - 1));
  assign is_end = (tbl_entry(idx) == 16'hFFFF);

  always_comb begin
    case (part)
      P_RST:   cur_pair = {8'h12, 8'h80};
      P_TBL:   cur_pair = tbl_entry(idx);
      default: cur_pair = {8'h15, 8'h20};
    endcase
    case (byte_k)
      2'd0:    cur_byte = DEV_ADDR;
      2'd1:    cur_byte = cur_pair[15:8];
      default: cur_byte = cur_pair[7:0];
    endcase
    tx_bit = (bit_i == 4'd8) ? 1'b1 : cur_byte[3'd7 - bit_i[2:0]];
  end

  always_comb begin
    scl_c = 1'b1;
    sda_c = 1'b1;
    if (state == S_XFER) begin
      case (tx)
        T_START: begin scl_c = (qtr != 2'd3); sda_c = (qtr < 2'd2); end
        T_BITS:  begin scl_c = (qtr == 2'd1) || (qtr == 2'd2); sda_c = tx_bit; end
        default: begin scl_c = (qtr != 2'd0); sda_c = (qtr >= 2'd2); end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      part   <= P_RST;
      tx     <= T_START;
      idx    <= '0;
      tick   <= '0;
      qtr    <= '0;
      byte_k <= '0;
      bit_i  <= '0;
      nack   <= 1'b0;
      wcnt   <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
      scl_lo <= 1'b0;
      sda_lo <= 1'b0;
      sda_m  <= 1'b1;
      sda_s  <= 1'b1;
    end else begin
      sda_m  <= sda_in;
      sda_s  <= sda_m;
      scl_lo <= !scl_c;
      sda_lo <= !sda_c;
      done   <= 1'b0;
      case (state)
        S_IDLE, S_FAIL: if (start) begin
          state  <= S_XFER;
          part   <= P_RST;
          tx     <= T_START;
          idx    <= '0;
          tick   <= '0;
          qtr    <= '0;
          byte_k <= '0;
          bit_i  <= '0;
          nack   <= 1'b0;
          err    <= 1'b0;
        end
        S_XFER: if (qstep) begin
          tick <= '0;
          qtr  <= qtr + 2'd1;
          case (tx)
            T_START: if (qtr == 2'd3) tx <= T_BITS;
            T_BITS: begin
              if (bit_i == 4'd8 && qtr == 2'd2 && sda_s) nack <= 1'b1;
              if (qtr == 2'd3) begin
                if (bit_i == 4'd8) begin
                  bit_i <= '0;
                  if (nack || byte_k == 2'd2) tx <= T_STOP;
                  else byte_k <= byte_k + 2'd1;
                end else begin
                  bit_i <= bit_i + 4'd1;
                end
              end
            end
            default: if (qtr == 2'd3) begin
              tx     <= T_START;
              byte_k <= '0;
              bit_i  <= '0;
              if (nack) begin
                state <= S_FAIL;
                err   <= 1'b1;
              end else begin
                case (part)
                  P_RST: begin
                    part  <= P_TBL;
                    idx   <= '0;
                    wcnt  <= WW'(RST_WAIT_CYC - 1);
                    state <= S_WAIT;
                  end
                  P_TBL: begin
                    idx   <= idx + 3'd1;
                    wcnt  <= WW'(GAP_CYC - 1);
                    state <= S_WAIT;
                  end
                  default: begin
                    done  <= 1'b1;
                    state <= S_IDLE;
                  end
                endcase
              end
            end
          endcase
        end else begin
          tick <= tick + QW'(1);
        end
        S_WAIT: if (wcnt == '0) begin
          state <= S_XFER;
          tick  <= '0;
          qtr   <= '0;
          if (part == P_TBL && is_end) part <= P_TAIL;
        end else begin
          wcnt <= wcnt - WW'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_SDA_MOVES_ONLY_WITH_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_c && $past(scl_c) && (sda_c != $past(sda_c))) |->
    (state == S_XFER && ((tx == T_START && !sda_c) || (tx == T_STOP && sda_c)))); // R2

  AST_BUS_FREE_OUTSIDE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_XFER) |-> (!scl_lo && !sda_lo)); // R2

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_EXCLUDES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !err); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err); // R9

  AST_FAIL_HALTS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FAIL && !start) |=> (state == S_FAIL)); // R9

  AST_START_IGNORED_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && start && wcnt != '0) |=> (state == S_WAIT && $stable(part) && $stable(idx))); // R10

endmodule

// File: tb/cam_reg_init_bench.sv
module cam_reg_init_bench;
  localparam int Q   = 4;
  localparam int GAP = 40;
  localparam int RW  = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, err, scl_lo, sda_lo;
  logic slave_lo = 1'b0;
  logic sda_in;

  assign sda_in = !(sda_lo || slave_lo);

  cam_reg_init #(.QDIV(Q), .GAP_CYC(GAP), .RST_WAIT_CYC(RW)) u_cam_reg_init (
    .clk(clk), .rst_n(rst_n), .start(start), .sda_in(sda_in),
    .done(done), .err(err), .scl_lo(scl_lo), .sda_lo(sda_lo));

  always #4 clk = !clk;

  int nchk = 0, nfail = 0;
  bit finished = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bus model state
  int ntx = 0, r = 0, nb = 0, ndone = 0, bad_per = 0, good_per = 0, long_done = 0;
  int nack_tx = -1, nack_byte = -1;
  bit in_tx = 0, p_scl = 1, p_sda = 1, p_done = 0;
  logic [7:0] sh;
  logic [7:0] rec [16][3];
  longint st_cyc [16];
  longint sp_cyc [16];
  int nbytes [16];
  longint last_rise = 0, done_cyc = 0;

  always @(negedge clk) begin
    bit scl_v, sda_v;
    scl_v = !scl_lo;
    sda_v = sda_in;
    if (rst_n) begin
      if (scl_v && p_scl && p_sda && !sda_v) begin
        in_tx = 1; r = 0; nb = 0;
        if (ntx < 16) st_cyc[ntx] = cyc;
      end else if (scl_v && p_scl && !p_sda && sda_v && in_tx) begin
        in_tx = 0;
        if (ntx < 16) begin sp_cyc[ntx] = cyc; nbytes[ntx] = nb; end
        ntx++;
      end else if (in_tx && scl_v && !p_scl) begin
        if (r > 0) begin
          if (cyc - last_rise != 4*Q) bad_per++; else good_per++;
        end
        last_rise = cyc;
        if (r < 8) sh = {sh[6:0], sda_v};
        r++;
      end else if (in_tx && !scl_v && p_scl) begin
        if (r == 8) begin
          if (ntx < 16) rec[ntx][nb] = sh;
          slave_lo = !(ntx == nack_tx && nb == nack_byte);
        end else if (r == 9) begin
          slave_lo = 1'b0; nb++; r = 0;
        end
      end
      if (done) begin
        ndone++; done_cyc = cyc;
        if (p_done) long_done = 1;
      end
      p_done = done;
    end
    p_scl = scl_v;
    p_sda = sda_v;
  end

  logic [7:0] exp_a [8] = '{8'h12, 8'h3A, 8'h0C, 8'hFF, 8'h40, 8'h55, 8'h11, 8'h15};
  logic [7:0] exp_d [8] = '{8'h80, 8'h04, 8'h04, 8'h00, 8'hC0, 8'hFF, 8'h0C, 8'h20};

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic clr_mon(input int ntx_n, input int nbyte_n);
    @(posedge clk); #1;
    ntx = 0; ndone = 0; bad_per = 0; good_per = 0; long_done = 0;
    nack_tx = ntx_n; nack_byte = nbyte_n;
  endtask

  task automatic pulse_start;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end;
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk); #1;
      if (ndone > 0 || err) break;
    end
    repeat (400) @(posedge clk);
    #1;
  endtask

  task automatic check_full_run(input string tag);
    chk(ntx == 8, {tag, " R7 transaction count"}, ntx, 8);
    for (int k = 0; k < 8; k++) begin
      string rq;
      rq = (k == 0) ? "R1 reset write" : (k == 7) ? "R7 closing write" :
           (k == 3 || k == 5) ? "R5 single-0xFF entry sent" : "R4 table entry";
      chk({rec[k][0], rec[k][1], rec[k][2]} == {8'h42, exp_a[k], exp_d[k]} && nbytes[k] == 3,
          {tag, " ", rq}, {rec[k][0], rec[k][1], rec[k][2]}, {8'h42, exp_a[k], exp_d[k]});
    end
    chk(st_cyc[1] - sp_cyc[0] >= RW && st_cyc[1] - sp_cyc[0] <= RW + 4*Q + 4,
        {tag, " R3 reset wait"}, st_cyc[1] - sp_cyc[0], RW);
    for (int k = 1; k < 7; k++)
      chk(st_cyc[k+1] - sp_cyc[k] >= GAP && st_cyc[k+1] - sp_cyc[k] <= GAP + 4*Q + 4,
          {tag, " R6 inter-write gap"}, st_cyc[k+1] - sp_cyc[k], GAP);
    chk(bad_per == 0 && good_per > 0, {tag, " R11 SCL period"}, bad_per, 0);
    chk(ndone == 1 && long_done == 0, {tag, " R8 single done pulse"}, ndone, 1);
    chk(done_cyc > sp_cyc[7] && done_cyc - sp_cyc[7] <= 2*Q + 4,
        {tag, " R8 done timing"}, done_cyc - sp_cyc[7], 2*Q);
    chk(err == 1'b0, {tag, " R8 err low after clean run"}, err, 0);
    chk(!scl_lo && !sda_lo, {tag, " R2 bus released after run"}, {scl_lo, sda_lo}, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(done == 0 && err == 0, "R8 reset outputs", {done, err}, 0);
    chk(!scl_lo && !sda_lo, "R2 bus released at reset", {scl_lo, sda_lo}, 0);
  endtask

  task automatic t_full;
    clr_mon(-1, -1);
    pulse_start();
    wait_end();
    check_full_run("full");
  endtask

  task automatic t_busy;
    clr_mon(-1, -1);
    pulse_start();
    repeat (100) @(posedge clk);
    pulse_start();
    repeat (450) @(posedge clk);
    pulse_start();
    repeat (1300) @(posedge clk);
    pulse_start();
    wait_end();
    chk(ntx == 8 && ndone == 1, "R10 start while busy ignored", ntx, 8);
    check_full_run("busy R10");
  endtask

  task automatic t_nack(input int txn, input int byten);
    clr_mon(txn, byten);
    pulse_start();
    wait_end();
    chk(err == 1'b1, "R9 err after missing acknowledge", err, 1);
    chk(ntx == txn + 1, "R9 no transaction after failure", ntx, txn + 1);
    chk(nbytes[txn] == byten + 1, "R9 transaction cut after nacked byte", nbytes[txn], byten + 1);
    chk(ndone == 0, "R9 no done on failure", ndone, 0);
    repeat (600) @(posedge clk); #1;
    chk(ntx == txn + 1 && err == 1'b1 && !scl_lo && !sda_lo, "R9 bus stays idle, err held",
        ntx, txn + 1);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(posedge clk);
    t_full();
    t_busy();
    t_nack(0, 0);
    t_nack(2, 1);
    t_nack(7, 2);
    t_full();
    finish_run();
  end
endmodule